// File: doc/BRIEF.md
# MESI snooping coherence controller

This block is the per-cache coherence engine for a private cache on an atomic snooping bus. It runs a four-state write-back invalidation protocol: invalid, shared, exclusive-clean and modified. It keeps a direct-mapped tag and state store. It serves processor reads and writes, and it asks for the bus when an access cannot finish locally. It also watches every transaction that other caches place on the bus and updates its own copy of each line to match.

On a read miss the controller samples a wired-OR shared input while the fill is granted. When no other cache claims the line, the line is installed exclusive-clean. A later write to that line then becomes modified without any bus traffic. Evictions are silent for clean lines, so a shared line may be the last remaining copy. A modified victim is written back before the fill. For every snooped address the controller drives its own contribution to the shared wire. It raises a flush strobe when a snooped read hits a dirty line.

Top module: `mesi_snoop_ctl`

## Requirements
- R1: After reset every line is invalid: no snoop address raises `shared_out` or `flush_out`, and `bus_req` is low.
- R2: A read miss granted with `bus_shared` low installs the line exclusive-clean. A later write to it completes in the cycle it is requested, with no bus request, and leaves the line modified.
- R3: A read miss granted with `bus_shared` high installs the line shared. A later write to it requests the bus with the upgrade command (code 3).
- R4: A read to a valid line, or a write to an exclusive-clean or modified line, raises `cpu_done` in the cycle of the request and does not raise `bus_req`.
- R5: A write to an invalid line requests the bus with the exclusive-read command (code 2) and installs the line modified.
- R6: A snooped read (code 1) of a modified line raises `flush_out` and `shared_out` in that cycle, and the line becomes shared.
- R7: A snooped read of an exclusive-clean or shared line raises `shared_out` only, and the line ends up shared.
- R8: A snooped exclusive-read (code 2) or upgrade (code 3) of a valid line raises `shared_out` and invalidates the line.
- R9: `shared_out` is high exactly when `snp_valid` is high and the line at `snp_addr` is valid with a matching tag. `flush_out` never rises for other commands. A snooped writeback (code 0) leaves the line state unchanged.
- R10: A miss whose set holds a modified line with another tag first requests the bus with the writeback command (code 0) at the victim address, then requests the fill. A clean victim is dropped with no writeback.
- R11: If a pending upgrade loses its shared copy to a snooped invalidation before the grant, the request turns into an exclusive-read.
- R12: `bus_req` holds its command and address until `bus_gnt`, unless a snoop changes the line. A granted fill raises `cpu_done` in the grant cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Processor access request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Line address of the access |
| cpu_done | output | 1 | Access completes this cycle |
| bus_req | output | 1 | Bus transaction wanted |
| bus_cmd | output | 2 | 0 writeback, 1 read, 2 exclusive-read, 3 upgrade |
| bus_addr | output | ADDR_W | Line address of the transaction |
| bus_gnt | input | 1 | Transaction performed this cycle |
| bus_shared | input | 1 | Wired-OR of other caches' shared outputs, sampled on grant |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of the snooped transaction |
| snp_addr | input | ADDR_W | Line address of the snooped transaction |
| shared_out | output | 1 | This cache holds a valid copy of `snp_addr` |
| flush_out | output | 1 | Dirty data must be supplied for the snooped read |

## Verification
The checker relies on the atomic bus. A snoop never appears in the same cycle as a grant to this cache. The processor holds `cpu_req`, `cpu_we` and `cpu_addr` steady until `cpu_done`. The bench keeps within these rules: it issues snoops only while the processor side is idle. The one exception is the upgrade-loss case, where the snoop is driven in a cycle with the grant held low. The bench drops the grant and request on the negative edge after the accepting cycle.

// File: rtl/mesi_snoop_ctl.sv
module mesi_snoop_ctl #(
  parameter int ADDR_W = 8,
  parameter int IDX_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  output logic              cpu_done,
  output logic              bus_req,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_gnt,
  input  logic              bus_shared,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              shared_out,
  output logic              flush_out
);
  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  localparam logic [1:0] ST_I = 2'd0, ST_S = 2'd1, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [1:0] CMD_WB = 2'd0, CMD_RD = 2'd1, CMD_RDX = 2'd2, CMD_UPG = 2'd3;

  logic [TAG_W-1:0] tag_q [SETS];
  logic [1:0]       st_q  [SETS];
  logic             busy_q;

  function automatic logic [1:0] after_snoop(input logic [1:0] st, input logic [1:0] cmd);
    case (cmd)
      CMD_RD:           after_snoop = (st == ST_I) ? ST_I : ST_S;
      CMD_RDX, CMD_UPG: after_snoop = ST_I;
      default:          after_snoop = st;
    endcase
  endfunction

  wire [IDX_W-1:0] c_idx = cpu_addr[IDX_W-1:0];
  wire [TAG_W-1:0] c_tag = cpu_addr[ADDR_W-1:IDX_W];
  wire [IDX_W-1:0] s_idx = snp_addr[IDX_W-1:0];
  wire [TAG_W-1:0] s_tag = snp_addr[ADDR_W-1:IDX_W];

  wire s_hit = snp_valid && st_q[s_idx] != ST_I && tag_q[s_idx] == s_tag;
  assign shared_out = s_hit;
  assign flush_out  = s_hit && snp_cmd == CMD_RD && st_q[s_idx] == ST_M;

  wire [1:0] c_st = (s_hit && s_idx == c_idx) ? after_snoop(st_q[c_idx], snp_cmd) : st_q[c_idx];
  wire c_match = c_st != ST_I && tag_q[c_idx] == c_tag;
  wire hit_ok  = c_match && (!cpu_we || c_st == ST_E || c_st == ST_M);
  wire idle_done = !busy_q && cpu_req && hit_ok;

  wire victim_dirty = st_q[c_idx] == ST_M && tag_q[c_idx] != c_tag;
  wire upg_ok       = st_q[c_idx] == ST_S && tag_q[c_idx] == c_tag;

  always_comb begin
    if (victim_dirty)  bus_cmd = CMD_WB;
    else if (!cpu_we)  bus_cmd = CMD_RD;
    else if (upg_ok)   bus_cmd = CMD_UPG;
    else               bus_cmd = CMD_RDX;
  end

  assign bus_addr = victim_dirty ? {tag_q[c_idx], c_idx} : cpu_addr;
  assign bus_req  = busy_q;
  wire fill_done  = busy_q && bus_gnt && bus_cmd != CMD_WB;
  assign cpu_done = idle_done || fill_done;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      for (int i = 0; i < SETS; i++) begin
        st_q[i]  <= ST_I;
        tag_q[i] <= '0;
      end
    end else begin
      if (s_hit)
        st_q[s_idx] <= after_snoop(st_q[s_idx], snp_cmd);
      if (!busy_q && cpu_req && !hit_ok)
        busy_q <= 1'b1;
      if (idle_done && cpu_we)
        st_q[c_idx] <= ST_M;
      if (busy_q && bus_gnt) begin
        if (bus_cmd == CMD_WB) begin
          st_q[c_idx] <= ST_I;
        end else begin
          tag_q[c_idx] <= c_tag;
          st_q[c_idx]  <= (bus_cmd == CMD_RD) ? (bus_shared ? ST_S : ST_E) : ST_M;
          busy_q       <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/mesi_snoop_ctl_chk.sv
module mesi_snoop_ctl_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_req,
  input logic              cpu_done,
  input logic              bus_req,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_gnt,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic [ADDR_W-1:0] snp_addr,
  input logic              shared_out,
  input logic              flush_out
);
  AST_FLUSH_ONLY_READ_HIT: assert property (@(posedge clk) disable iff (rst)
    flush_out |-> snp_valid && snp_cmd == 2'd1 && shared_out); // R9

  AST_NO_REPEAT_FLUSH: assert property (@(posedge clk) disable iff (rst)
    snp_valid && snp_cmd == 2'd1 && $past(flush_out) && !$past(bus_gnt)
      && snp_addr == $past(snp_addr) |-> !flush_out); // R6

  AST_DONE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    cpu_done |-> cpu_req); // R4

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
    bus_req && !bus_gnt && !snp_valid |=> bus_req && $stable(bus_cmd) && $stable(bus_addr)); // R12

  AST_FILL_COMPLETES: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt && bus_cmd != 2'd0 |-> cpu_done); // R12

  AST_WB_THEN_FILL: assert property (@(posedge clk) disable iff (rst)
    bus_req && bus_gnt && bus_cmd == 2'd0 |=> bus_req && bus_cmd != 2'd0); // R10

  AST_GNT_NOT_WITH_SNOOP: assert property (@(posedge clk) disable iff (rst)
    !(bus_req && bus_gnt && snp_valid)); // R12
endmodule

bind mesi_snoop_ctl mesi_snoop_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (.*);

// File: tb/mesi_snoop_ctl_tb.sv
module mesi_snoop_ctl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam logic [1:0] S_I = 0, S_S = 1, S_E = 2, S_M = 3;
  localparam logic [1:0] C_WB = 0, C_RD = 1, C_RDX = 2, C_UPG = 3;

  logic clk = 0, rst = 1;
  logic cpu_req = 0, cpu_we = 0;
  logic [AW-1:0] cpu_addr = 0;
  logic cpu_done, bus_req;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic bus_gnt = 0, bus_shared = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = 0;
  logic shared_out, flush_out;

  int checks = 0, errors = 0;
  bit ended = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mesi_snoop_ctl #(.ADDR_W(AW), .IDX_W(2)) dut_i (
    .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_done(cpu_done), .bus_req(bus_req), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_gnt(bus_gnt), .bus_shared(bus_shared), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
    .snp_addr(snp_addr), .shared_out(shared_out), .flush_out(flush_out));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic snoop(input logic [AW-1:0] a, input logic [1:0] c, output logic sh, output logic fl);
    @(negedge clk);
    snp_valid = 1; snp_cmd = c; snp_addr = a;
    #1 sh = shared_out; fl = flush_out;
    @(posedge clk);
    @(negedge clk);
    snp_valid = 0;
  endtask

  task automatic cpu_op(input logic [AW-1:0] a, input logic we, input logic shr,
                        output int nbus, output logic [1:0] lcmd,
                        output logic wbs, output logic [AW-1:0] wba);
    bit fin;
    logic d;
    nbus = 0; lcmd = 0; wbs = 0; wba = 0; fin = 0;
    @(negedge clk);
    cpu_addr = a; cpu_we = we; cpu_req = 1;
    for (int n = 0; n < 40 && !fin; n++) begin
      #1;
      if (cpu_done) begin
        @(posedge clk); @(negedge clk);
        cpu_req = 0; fin = 1;
      end else if (bus_req) begin
        nbus++;
        if (bus_cmd == C_WB) begin wbs = 1; wba = bus_addr; end
        else lcmd = bus_cmd;
        bus_gnt = 1; bus_shared = shr;
        #1 d = cpu_done;
        @(posedge clk); @(negedge clk);
        bus_gnt = 0; bus_shared = 0;
        if (d) begin cpu_req = 0; fin = 1; end
      end else begin
        @(negedge clk);
      end
    end
    if (!fin) begin
      chk(0, "R12 access never completed", 0, 1);
      cpu_req = 0;
    end
  endtask

  function automatic logic [1:0] ref_next(input logic [1:0] st, input int op);
    case (op)
      0: ref_next = (st == S_I) ? S_E : st;
      1: ref_next = (st == S_I) ? S_S : st;
      2: ref_next = S_M;
      3: ref_next = (st == S_I) ? S_I : S_S;
      4, 5: ref_next = S_I;
      default: ref_next = st;
    endcase
  endfunction

  function automatic string op_tag(input int op, input logic [1:0] st);
    case (op)
      0: op_tag = "R2";
      1: op_tag = "R3";
      2: op_tag = "R5";
      3: op_tag = (st == S_M) ? "R6" : "R7";
      4, 5: op_tag = "R8";
      default: op_tag = "R9";
    endcase
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    int nb;
    logic [1:0] lc;
    logic wbs, sh, fl;
    logic [AW-1:0] wba;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;

    // R1: every address reads back invalid
    #1 chk(bus_req == 0, "R1 bus_req after reset", bus_req, 0);
    for (int a = 0; a < (1 << AW); a++) begin
      snoop(a[AW-1:0], C_RD, sh, fl);
      chk(sh == 0 && fl == 0, "R1 line valid after reset", {sh, fl}, 0);
    end

    // Sweep: every set, start state, operation and probe
    for (int s = 0; s < 4; s++)
      for (int st = 0; st < 4; st++)
        for (int op = 0; op < 7; op++)
          for (int pr = 0; pr < 2; pr++) begin
            logic [AW-1:0] a;
            logic [1:0] nx;
            string tg;
            a = {6'd0, s[1:0]};
            nx = ref_next(st[1:0], op);
            tg = op_tag(op, st[1:0]);
            snoop(a, C_RDX, sh, fl);
            if (st == S_S) cpu_op(a, 0, 1, nb, lc, wbs, wba);
            if (st == S_E) cpu_op(a, 0, 0, nb, lc, wbs, wba);
            if (st == S_M) cpu_op(a, 1, 0, nb, lc, wbs, wba);
            if (op <= 1) begin
              cpu_op(a, 0, op == 1, nb, lc, wbs, wba);
              if (st == S_I) chk(nb == 1 && lc == C_RD, tg, lc, C_RD);
              else chk(nb == 0, "R4 read hit used bus", nb, 0);
            end else if (op == 2) begin
              cpu_op(a, 1, 0, nb, lc, wbs, wba);
              if (st == S_E || st == S_M) chk(nb == 0, "R4 write hit used bus", nb, 0);
              else if (st == S_S) chk(nb == 1 && lc == C_UPG, "R3 upgrade", lc, C_UPG);
              else chk(nb == 1 && lc == C_RDX, "R5 exclusive read", lc, C_RDX);
            end else begin
              logic [1:0] c;
              c = (op == 3) ? C_RD : (op == 4) ? C_RDX : (op == 5) ? C_UPG : C_WB;
              snoop(a, c, sh, fl);
              chk(sh == (st != S_I), {tg, " shared_out"}, sh, st != S_I);
              chk(fl == (op == 3 && st == S_M), {tg, " flush_out"}, fl, op == 3 && st == S_M);
            end
            if (pr == 0) begin
              int cls, ecls;
              cpu_op(a, 1, 0, nb, lc, wbs, wba);
              cls = (nb == 0) ? 2 : (lc == C_UPG) ? 1 : 0;
              ecls = (nx == S_E || nx == S_M) ? 2 : (nx == S_S) ? 1 : 0;
              chk(cls == ecls, {tg, " state by write probe"}, cls, ecls);
            end else begin
              int cls, ecls;
              snoop(a, C_RD, sh, fl);
              cls = !sh ? 0 : fl ? 2 : 1;
              ecls = (nx == S_I) ? 0 : (nx == S_M) ? 2 : 1;
              chk(cls == ecls, {tg, " state by snoop probe"}, cls, ecls);
            end
          end

    for (int s = 0; s < 4; s++) snoop({6'd0, s[1:0]}, C_RDX, sh, fl);

    // R10: dirty victim written back first, clean victim dropped
    cpu_op({6'd9, 2'd1}, 1, 0, nb, lc, wbs, wba);
    cpu_op({6'd10, 2'd1}, 0, 0, nb, lc, wbs, wba);
    chk(wbs == 1 && wba == {6'd9, 2'd1}, "R10 writeback of dirty victim", wba, {6'd9, 2'd1});
    chk(nb == 2 && lc == C_RD, "R10 fill after writeback", nb, 2);
    snoop({6'd9, 2'd1}, C_RD, sh, fl);
    chk(sh == 0, "R10 victim left valid", sh, 0);
    cpu_op({6'd11, 2'd1}, 0, 0, nb, lc, wbs, wba);
    chk(wbs == 0 && nb == 1, "R10 clean victim wrote back", nb, 1);

    // R11 and R12: upgrade held, then lost to a snooped invalidation
    cpu_op({6'd20, 2'd2}, 0, 1, nb, lc, wbs, wba);
    @(negedge clk);
    cpu_addr = {6'd20, 2'd2}; cpu_we = 1; cpu_req = 1;
    #1 chk(cpu_done == 0, "R3 write to shared completed locally", cpu_done, 0);
    @(negedge clk); #1;
    chk(bus_req == 1 && bus_cmd == C_UPG, "R3 upgrade requested", bus_cmd, C_UPG);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #1;
      chk(bus_req == 1 && bus_cmd == C_UPG && bus_addr == {6'd20, 2'd2}, "R12 request held", bus_cmd, C_UPG);
    end
    @(negedge clk);
    snp_valid = 1; snp_cmd = C_RDX; snp_addr = {6'd20, 2'd2};
    @(negedge clk);
    snp_valid = 0;
    #1 chk(bus_req == 1 && bus_cmd == C_RDX, "R11 lost upgrade became exclusive read", bus_cmd, C_RDX);
    bus_gnt = 1;
    #1 chk(cpu_done == 1, "R12 done on grant", cpu_done, 1);
    @(posedge clk); @(negedge clk);
    bus_gnt = 0; cpu_req = 0;
    snoop({6'd20, 2'd2}, C_RD, sh, fl);
    chk(fl == 1, "R11 line modified after exclusive read", fl, 1);

    finish_run();
  end
endmodule